// File: doc/BRIEF.md
# Floppy Controller Data FIFO with Status Generation

This block sits between the media side of a floppy disk controller and the host bus. It holds data bytes in a small circular buffer and moves them to or from the host either by DMA (request, acknowledge and terminal count) or by programmed I/O through a data port. During the execution phase it also produces the main status byte that the host polls. Command decoding, drive control, bit encoding and the result phase belong to other blocks. This block sees three control inputs from them: a configure strobe with its parameter byte, a pulse when a command's last parameter byte has been accepted, and the direction and transfer mode held for the whole execution phase.

The active buffer length is set at run time. It equals the configure byte's low threshold field plus one. Setting bit 5 of the configure byte turns buffering off, and every byte then moves on its own. In DMA mode, data moves in whole-buffer bursts. Toward the host, bytes collect until the buffer is full or the last byte of the sector arrives, and then the buffer is drained to DMA. Toward the media, an empty buffer is refilled from DMA until it is full, and then the media side consumes it.

Both media-side interfaces are valid/ready streams. Inbound: a byte moves on a clock edge where `mi_valid` and `mi_ready` are both high. `mi_ready` is low outside a to-host execution phase, while a burst is being drained, and while the buffer is full. The source must hold its byte and last flag steady until the byte is accepted. Outbound: `mo_valid` is high only in a to-media execution phase, with data buffered and no refill in progress. The sink asserts `mo_ready` to take a byte and sets `mo_last` in the same cycle when that byte ends the transfer.

Top module: `fdx_data_fifo`

## Requirements
- R1: After reset the status reads 0x80, DRQ, overrun, `mi_ready` and `mo_valid` are low, buffering is enabled and the active length is 1.
- R2: A configure strobe sets the active length to (byte[3:0] + 1), or to 1 when byte[5] is set. A configure strobe or a parameters-complete pulse empties the buffer and clears the overrun flag, and configure returns the status to 0x80.
- R3: Bytes leave in the order they entered, and read and write positions wrap at the active length, so streams longer than that length stay intact.
- R4: While DMA execution is under way the status reads 0x50 toward the host and 0x10 toward the media, and bit 7 (RQM) is never set while DRQ is high.
- R5: During programmed-I/O execution, status bit 7 is set exactly while a drain or refill window is open. Toward the host the status reads 0xF0 or 0x70, and toward the media it reads 0xB0 or 0x30.
- R6: Toward the host, the drain window opens in the cycle after the buffer reaches the active length or takes a byte flagged last. While the window is open, `mi_ready` is low, and in DMA mode DRQ stays high until the buffer is empty.
- R7: Toward the media, the refill window opens at the start of execution and closes when the buffer is full. It reopens when a media pop that is not flagged last empties the buffer. A media pop flagged last ends execution (status 0x80).
- R8: A programmed-I/O host write that fills the buffer clears status bit 7 from the next cycle.
- R9: A host write while the buffer is full is dropped and sets the sticky overrun flag.
- R10: A host read while the buffer is empty leaves the buffer unchanged and returns the byte most recently read.
- R11: DACK with terminal count ends the DMA window, and DRQ is low from the next cycle. Toward the host, execution ends at once. Toward the media, no refill follows and execution ends on the last media pop.
- R12: Toward the host, execution ends (status 0x80) when a host read empties the buffer after a byte flagged last has been taken.
- R13: DACK is ignored while DRQ is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configure strobe |
| cfg_byte | input | 8 | Configure parameter byte (bit 5 bypass, [3:0] threshold) |
| params_done | input | 1 | Pulse: last parameter accepted, execution starts |
| dir_to_host | input | 1 | 1 = media to host, 0 = host to media |
| dma_mode | input | 1 | 1 = DMA transfer, 0 = programmed I/O |
| mi_valid | input | 1 | Media byte offered toward host |
| mi_ready | output | 1 | Block accepts the media byte |
| mi_data | input | 8 | Media byte toward host |
| mi_last | input | 1 | Offered byte is the final one |
| mo_valid | output | 1 | Byte available for the media side |
| mo_ready | input | 1 | Media side takes the byte |
| mo_data | output | 8 | Byte toward the media |
| mo_last | input | 1 | The byte being taken ends the transfer |
| drq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge, one byte per cycle |
| tc | input | 1 | Terminal count, qualified by DACK |
| host_rd | input | 1 | Programmed-I/O data read strobe |
| host_wr | input | 1 | Programmed-I/O data write strobe |
| host_wdata | input | 8 | Host byte for DMA or programmed-I/O writes |
| host_rdata | output | 8 | Byte at the head of the buffer, or the last byte read when empty |
| status | output | 8 | Main status byte (7 RQM, 6 direction, 5 non-DMA, 4 busy) |
| overrun | output | 1 | Sticky host-write overrun flag |

## Verification
Properties placed beside the logic check four things on every cycle: the fill level never exceeds the active length, a flush empties the buffer, a write into a full buffer raises overrun, and an empty read leaves the head stable. They also check that RQM and DRQ are never both high and that DRQ drops after terminal count. The ordering and wrap of data across repeated bursts with random lengths and thresholds can only be shown by the bench scenarios. The same holds for the exact status values in each direction and mode, the reopening of refill after a non-final pop, and the ignored acknowledge.

// File: rtl/fdx_pkg.sv
`timescale 1ns/1ps
package fdx_pkg;
  // status byte bit positions
  localparam int ST_RQM  = 7;
  localparam int ST_DIO  = 6;
  localparam int ST_NDMA = 5;
  localparam int ST_BUSY = 4;
  // configure byte: bypass bit
  localparam int CFG_BYPASS_BIT = 5;
  localparam logic [7:0] ST_IDLE = 8'h80;

  function automatic logic [7:0] make_status(input logic rqm, input logic dio,
                                             input logic ndma, input logic busy);
    logic [7:0] s;
    s = '0;
    s[ST_RQM]  = rqm;
    s[ST_DIO]  = dio;
    s[ST_NDMA] = ndma;
    s[ST_BUSY] = busy;
    return s;
  endfunction
endpackage

// File: rtl/fdx_ring.sv
`timescale 1ns/1ps
module fdx_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] len,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overrun
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [DW-1:0] last_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [CW-1:0] n);
    if (CW'(p) + CW'(1) >= n) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (count == len);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = empty ? last_q : mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count   <= '0;
      last_q  <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wr_q <= adv(wr_q, len);
      if (do_pop) begin
        rd_q   <= adv(rd_q, len);
        last_q <= mem[rd_q];
      end
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && full) overrun <= 1'b1;
    end
  end

  // R2
  ring_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= len);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !flush) |=> (overrun && full));
  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> (empty && $stable(head)));
endmodule

// File: rtl/fdx_seq.sv
`timescale 1ns/1ps
module fdx_seq
  import fdx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_flush,
  input  logic          params_done,
  input  logic          dir_to_host,
  input  logic          dma_mode,
  input  logic          dack,
  input  logic          tc,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          mi_valid,
  input  logic          mi_last,
  input  logic          mo_ready,
  input  logic          mo_last,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] len,
  input  logic          full,
  input  logic          empty,
  output logic          mi_ready,
  output logic          mo_valid,
  output logic          ring_push,
  output logic          ring_pop,
  output logic          drq,
  output logic [7:0]    status
);
  logic exec_q, drain_q, fill_q, last_seen_q, stop_q;
  logic dma_go, tc_hit, host_push, host_pop, med_push, med_pop;
  logic push_ok, pop_ok, reach_len;

  assign drq       = exec_q && dma_mode && (drain_q || fill_q);
  assign dma_go    = dma_mode && drq && dack;
  assign tc_hit    = dma_go && tc;
  assign host_push = exec_q && !dir_to_host && (dma_mode ? dma_go : host_wr);
  assign host_pop  = exec_q &&  dir_to_host && (dma_mode ? dma_go : host_rd);
  assign mi_ready  = exec_q &&  dir_to_host && !drain_q && !full;
  assign mo_valid  = exec_q && !dir_to_host && !fill_q && !empty;
  assign med_push  = mi_valid && mi_ready;
  assign med_pop   = mo_valid && mo_ready;
  assign ring_push = med_push || host_push;
  assign ring_pop  = med_pop || host_pop;
  assign push_ok   = host_push && !full;
  assign pop_ok    = host_pop && !empty;
  assign reach_len = (count + CW'(1) == len);

  always_ff @(posedge clk) begin
    if (rst || cfg_flush) begin
      exec_q      <= 1'b0;
      drain_q     <= 1'b0;
      fill_q      <= 1'b0;
      last_seen_q <= 1'b0;
      stop_q      <= 1'b0;
    end else if (params_done) begin
      exec_q      <= 1'b1;
      drain_q     <= 1'b0;
      fill_q      <= !dir_to_host;
      last_seen_q <= 1'b0;
      stop_q      <= 1'b0;
    end else if (tc_hit) begin
      stop_q  <= 1'b1;
      drain_q <= 1'b0;
      fill_q  <= 1'b0;
      if (dir_to_host) exec_q <= 1'b0;
    end else if (dir_to_host) begin
      if (pop_ok && count == CW'(1) && !med_push) begin
        drain_q <= 1'b0;
        if (last_seen_q) exec_q <= 1'b0;
      end
      if (med_push && mi_last) last_seen_q <= 1'b1;
      if (med_push && (reach_len || mi_last)) drain_q <= 1'b1;
    end else begin
      if (push_ok && reach_len) fill_q <= 1'b0;
      if (med_pop && mo_last) begin
        exec_q <= 1'b0;
        fill_q <= 1'b0;
      end else if (med_pop && count == CW'(1) && !push_ok && !stop_q) begin
        fill_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (!exec_q)      status = ST_IDLE;
    else if (dma_mode) status = make_status(1'b0, dir_to_host, 1'b0, 1'b1);
    else               status = make_status(drain_q || fill_q, dir_to_host, 1'b1, 1'b1);
  end

  // R11
  tc_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tc_hit && !params_done && !cfg_flush) |=> !drq);
  // R8
  pio_full_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_q && !dma_mode && push_ok && reach_len && !params_done && !cfg_flush)
      |=> !status[ST_RQM]);
  // R6
  drain_open_chk: assert property (@(posedge clk) disable iff (rst)
    (med_push && mi_last && !params_done && !cfg_flush) |=> !mi_ready);
  // R7
  last_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (med_pop && mo_last && !params_done && !cfg_flush) |=> (status == ST_IDLE));
endmodule

// File: rtl/fdx_data_fifo.sv
`timescale 1ns/1ps
module fdx_data_fifo
  import fdx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_valid,
  input  logic [7:0]    cfg_byte,
  input  logic          params_done,
  input  logic          dir_to_host,
  input  logic          dma_mode,
  input  logic          mi_valid,
  output logic          mi_ready,
  input  logic [DW-1:0] mi_data,
  input  logic          mi_last,
  output logic          mo_valid,
  input  logic          mo_ready,
  output logic [DW-1:0] mo_data,
  input  logic          mo_last,
  output logic          drq,
  input  logic          dack,
  input  logic          tc,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [7:0]    status,
  output logic          overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] thr_q;
  logic          bypass_q;
  logic [CW-1:0] len, count;
  logic          full, empty, ring_push, ring_pop, flush;
  logic [DW-1:0] head, push_data;
  logic          unused_cfg;

  assign unused_cfg = ^cfg_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= '0;
      bypass_q <= 1'b0;
    end else if (cfg_valid) begin
      thr_q    <= cfg_byte[AW-1:0];
      bypass_q <= cfg_byte[CFG_BYPASS_BIT];
    end
  end

  assign len       = bypass_q ? CW'(1) : CW'(thr_q) + CW'(1);
  assign flush     = cfg_valid || params_done;
  assign push_data = dir_to_host ? mi_data : host_wdata;
  assign host_rdata = head;
  assign mo_data    = head;

  fdx_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk(clk), .rst(rst), .flush(flush), .len(len),
    .push(ring_push), .push_data(push_data), .pop(ring_pop),
    .head(head), .count(count), .full(full), .empty(empty), .overrun(overrun)
  );

  fdx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .cfg_flush(cfg_valid), .params_done(params_done),
    .dir_to_host(dir_to_host), .dma_mode(dma_mode), .dack(dack), .tc(tc),
    .host_rd(host_rd), .host_wr(host_wr), .mi_valid(mi_valid), .mi_last(mi_last),
    .mo_ready(mo_ready), .mo_last(mo_last), .count(count), .len(len),
    .full(full), .empty(empty), .mi_ready(mi_ready), .mo_valid(mo_valid),
    .ring_push(ring_push), .ring_pop(ring_pop), .drq(drq), .status(status)
  );

  // R4
  rqm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    drq |-> (!status[ST_RQM] && status[ST_BUSY] && (status[ST_DIO] == dir_to_host)));
  // R6
  stall_on_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (drq && dir_to_host) |-> !mi_ready);
endmodule

// File: tb/test_fdx_data_fifo.sv
`timescale 1ns/1ps
module test_fdx_data_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic cfg_valid = 0; logic [7:0] cfg_byte = 0;
  logic params_done = 0, dir_to_host = 0, dma_mode = 0;
  logic mi_valid = 0, mi_last = 0; logic [7:0] mi_data = 0;
  logic mi_ready, mo_valid, drq, overrun;
  logic mo_ready = 0, mo_last = 0;
  logic [7:0] mo_data, host_rdata, status;
  logic dack = 0, tc = 0, host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = 0;

  int vectors = 0, errs = 0;
  logic [7:0] pat [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  fdx_data_fifo i_fdx_data_fifo (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
    .params_done(params_done), .dir_to_host(dir_to_host), .dma_mode(dma_mode),
    .mi_valid(mi_valid), .mi_ready(mi_ready), .mi_data(mi_data), .mi_last(mi_last),
    .mo_valid(mo_valid), .mo_ready(mo_ready), .mo_data(mo_data), .mo_last(mo_last),
    .drq(drq), .dack(dack), .tc(tc), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .status(status), .overrun(overrun)
  );

  function automatic int exp_len(input logic [7:0] cb);
    return cb[5] ? 1 : int'(cb[3:0]) + 1;
  endfunction

  function automatic logic [7:0] exp_status(input bit exec, input bit dma,
                                            input bit to_host, input bit rqm);
    if (!exec) return 8'h80;
    if (dma) return to_host ? 8'h50 : 8'h10;
    return {rqm, to_host, 2'b11, 4'b0000};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic fill_pat();
    for (int i = 0; i < 64; i++) pat[i] = 8'($urandom);
  endtask

  task automatic configure(input logic [7:0] cb);
    cfg_valid = 1; cfg_byte = cb; step(); cfg_valid = 0;
  endtask

  task automatic start(input bit to_host, input bit dma);
    dir_to_host = to_host; dma_mode = dma; params_done = 1; step(); params_done = 0;
  endtask

  task automatic run_m2h(input logic [7:0] cb, input int n);
    int l, held, rd;
    l = exp_len(cb); held = 0; rd = 0;
    fill_pat(); configure(cb); start(1, 1);
    chk("R4 to-host dma status", status, exp_status(1, 1, 1, 0));
    for (int i = 0; i < n; i++) begin
      mi_valid = 1; mi_data = pat[i]; mi_last = (i == n - 1);
      while (!mi_ready) step();
      step(); mi_valid = 0; mi_last = 0; held++;
      if (held == l || i == n - 1) begin
        chk("R6 drq after burst fill", 8'(drq), 8'd1);
        chk("R6 media stalled while draining", 8'(mi_ready), 8'd0);
        chk("R4 rqm clear during dma", status, exp_status(1, 1, 1, 0));
        while (held > 0) begin
          chk("R3 byte order/wrap", host_rdata, pat[rd]);
          dack = 1; step(); dack = 0; held--; rd++;
        end
        chk("R6 drq low once empty", 8'(drq), 8'd0);
        chk(i == n - 1 ? "R12 end after last" : "R6 resume collect", status,
            exp_status(i != n - 1, 1, 1, 0));
      end else begin
        chk("R6 no early drq", 8'(drq), 8'd0);
      end
    end
  endtask

  task automatic run_h2m(input logic [7:0] cb, input int n);
    int l, sent, got, held;
    l = exp_len(cb); sent = 0; got = 0; held = 0;
    fill_pat(); configure(cb); start(0, 1);
    chk("R7 drq at start", 8'(drq), 8'd1);
    chk("R4 to-media dma status", status, exp_status(1, 1, 0, 0));
    while (got < n) begin
      while (drq && sent < n) begin
        dack = 1; host_wdata = pat[sent]; tc = (sent == n - 1);
        step(); dack = 0; tc = 0; sent++; held++;
      end
      if (sent < n) chk("R7 refill stops when full", 8'(held), 8'(l));
      chk("R11 drq low after burst/tc", 8'(drq), 8'd0);
      while (held > 0) begin
        chk("R7 media valid", 8'(mo_valid), 8'd1);
        chk("R3 media order/wrap", mo_data, pat[got]);
        mo_ready = 1; mo_last = (got == n - 1); step(); mo_ready = 0; mo_last = 0;
        got++; held--;
      end
      if (got < n) chk("R7 refill reopens", 8'(drq), 8'd1);
      else chk("R7 last pop ends exec", status, 8'h80);
    end
  endtask

  initial begin
    void'($urandom(32'd20240225));
    fill_pat();
    repeat (3) step();
    rst = 0;
    step();
    // R1
    chk("R1 status idle", status, 8'h80);
    chk("R1 drq", 8'(drq), 8'd0);
    chk("R1 overrun", 8'(overrun), 8'd0);
    chk("R1 mi_ready", 8'(mi_ready), 8'd0);
    chk("R1 mo_valid", 8'(mo_valid), 8'd0);
    // R1: default length 1 -> one byte opens a drain burst
    start(1, 1);
    mi_valid = 1; mi_data = 8'h3C; mi_last = 0; step(); mi_valid = 0;
    chk("R1 default length one", 8'(drq), 8'd1);
    chk("R1 head", host_rdata, 8'h3C);

    // R5 R8 R9 R2: programmed-I/O writes toward media, length 4
    configure(8'h03); start(0, 0);
    chk("R5 to-media pio waiting", status, 8'hB0);
    for (int i = 0; i < 4; i++) begin
      host_wr = 1; host_wdata = pat[i]; step(); host_wr = 0;
      chk(i == 3 ? "R8 full write clears rqm" : "R5 still waiting", status,
          i == 3 ? 8'h30 : 8'hB0);
    end
    host_wr = 1; host_wdata = 8'h5A; step(); host_wr = 0;
    chk("R9 overrun on full write", 8'(overrun), 8'd1);
    for (int i = 0; i < 4; i++) begin
      chk("R9 dropped byte absent", mo_data, pat[i]);
      mo_ready = 1; step(); mo_ready = 0;
    end
    chk("R5 refill reopens pio", status, 8'hB0);
    chk("R9 overrun sticky", 8'(overrun), 8'd1);
    configure(8'h03);
    chk("R2 configure clears overrun", 8'(overrun), 8'd0);
    chk("R2 configure idles status", status, 8'h80);

    // R10 R12 R2 R5: bypass, programmed-I/O reads toward host
    configure(8'h27); start(1, 0);
    chk("R5 to-host pio no data", status, 8'h70);
    mi_valid = 1; mi_data = 8'hA1; step(); mi_valid = 0;
    chk("R2 bypass gives length one", status, 8'hF0);
    chk("R6 stalled", 8'(mi_ready), 8'd0);
    chk("R10 head data", host_rdata, 8'hA1);
    host_rd = 1; step(); host_rd = 0;
    chk("R5 window closes", status, 8'h70);
    host_rd = 1; step(); host_rd = 0;
    chk("R10 empty read keeps last", host_rdata, 8'hA1);
    chk("R10 status unchanged", status, 8'h70);
    mi_valid = 1; mi_data = 8'hB2; mi_last = 1; step(); mi_valid = 0; mi_last = 0;
    chk("R10 pointer intact", host_rdata, 8'hB2);
    host_rd = 1; step(); host_rd = 0;
    chk("R12 end after last read", status, 8'h80);

    // R13 R7 R11: ignored acknowledge, tc toward media
    fill_pat(); configure(8'h03); start(0, 1);
    for (int i = 0; i < 4; i++) begin
      dack = 1; host_wdata = pat[i]; step(); dack = 0;
    end
    chk("R7 full stops drq", 8'(drq), 8'd0);
    dack = 1; host_wdata = 8'hEE; step(); dack = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R13 dack without drq ignored", mo_data, pat[i]);
      mo_ready = 1; step(); mo_ready = 0;
    end
    chk("R7 drq after non-last empty", 8'(drq), 8'd1);
    dack = 1; tc = 1; host_wdata = pat[4]; step(); dack = 0; tc = 0;
    chk("R11 tc drops drq", 8'(drq), 8'd0);
    chk("R11 tc byte kept", mo_data, pat[4]);
    mo_ready = 1; mo_last = 1; step(); mo_ready = 0; mo_last = 0;
    chk("R11 no refill after tc", 8'(drq), 8'd0);
    chk("R7 last pop idles", status, 8'h80);

    // R11 toward host
    configure(8'h03); start(1, 1);
    for (int i = 0; i < 4; i++) begin
      mi_valid = 1; mi_data = pat[i]; step(); mi_valid = 0;
    end
    chk("R6 burst drq", 8'(drq), 8'd1);
    dack = 1; tc = 1; step(); dack = 0; tc = 0;
    chk("R11 to-host tc drq", 8'(drq), 8'd0);
    chk("R11 to-host tc ends exec", status, 8'h80);

    // random mix
    for (int k = 0; k < 16; k++) begin
      logic [7:0] cb;
      int n;
      cb = {2'b00, 1'($urandom), 1'b0, 4'($urandom)};
      n = 1 + int'($urandom % 40);
      if ($urandom % 2) run_m2h(cb, n);
      else run_h2m(cb, n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule